// File: doc/BRIEF.md
# Real-Mode and Virtual-8086 Segment Register Loader

This block holds the six segment register caches of a processor core and applies the loads that happen while protection is off (real mode) or while the core runs 16-bit tasks in virtual-8086 mode. Each load takes a register index, a 16-bit segment value and a mode flag. It then rewrites the cached selector, base, privilege and attribute fields of the chosen entry in one clock edge. No descriptor table lookup and no privilege test are made. The base is always the segment value times sixteen.

The two modes treat the attribute fields differently. A real-mode load rewrites only the selector, requested privilege, base, type and presence flags. It keeps the limit, granularity, operand-size, long and available bits and the descriptor privilege that the entry already held, so a large limit set up earlier stays in force. A virtual-8086 load forces a 64 KiB byte-granular 16-bit segment at privilege 3. A load of the code segment register sends a one-cycle flush request to the fetch unit, which discards its prefetch queue and recomputes its fetch mode. Any entry can be read at any time through a combinational read port.

Top module: `rv86_seg_loader`

## Requirements
- R1: After reset every entry reads as: selector 0, requested privilege 0, valid 1, present 1, non-system 1, type 4'b0011, descriptor privilege 0, base 0, raw limit 0xFFFF, scaled limit 0xFFFF, granularity, operand-size, long and available bits 0. The flush output is 0.
- R2: A write (`wr_en`=1, `wr_sel` below 6) stores `wr_value` as the selector and `{12'h000, wr_value, 4'h0}` as the base. Both are visible on the read port from the first clock edge after the write.
- R3: A written entry has requested privilege 0 when `v86_mode`=0 and 3 when `v86_mode`=1.
- R4: Every write sets valid=1, present=1 and non-system=1, and sets type to 4'b0011 (read/write data, accessed).
- R5: A write with `v86_mode`=0 leaves the descriptor privilege, both limits and the granularity, operand-size, long and available bits of that entry at their previous values.
- R6: A write with `v86_mode`=1 sets descriptor privilege 3, raw limit 0xFFFF and scaled limit 0xFFFF, and clears the granularity, operand-size, long and available bits.
- R7: Index 1 is the code segment. A write to index 1 raises `flush_req` for exactly the one cycle that follows the write edge. A write to any other index, and a cycle with `wr_en`=0, leave `flush_req` at 0.
- R8: A write changes only the selected entry. A cycle with `wr_en`=0, or with `wr_sel` of 6 or 7, changes no entry.
- R9: The read port shows the entry named by `rd_sel`. An `rd_sel` of 6 or 7 returns all fields as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load strobe |
| wr_sel | input | 3 | Index of the entry to load (1 = code segment) |
| wr_value | input | 16 | Segment value to load |
| v86_mode | input | 1 | 1 = virtual-8086 load, 0 = real-mode load |
| rd_sel | input | 3 | Index of the entry to read |
| rd_selector | output | 16 | Cached selector value |
| rd_rpl | output | 2 | Requested privilege of the selector |
| rd_valid | output | 1 | Entry valid |
| rd_present | output | 1 | Segment present |
| rd_nonsys | output | 1 | Code/data (non-system) segment |
| rd_type | output | 4 | Segment type |
| rd_dpl | output | 2 | Descriptor privilege |
| rd_base | output | 32 | Segment base |
| rd_limit_raw | output | 20 | Raw limit |
| rd_limit_scaled | output | 32 | Byte-scaled limit |
| rd_gran | output | 1 | Page granularity bit |
| rd_dsize | output | 1 | Default 32-bit operand size bit |
| rd_long | output | 1 | Long segment bit |
| rd_avail | output | 1 | Available bit |
| flush_req | output | 1 | One-cycle prefetch flush request |

## Verification
Suppose one entry held a wrong privilege or limit field. It would stay hidden until a later real-mode load kept that field, and would then show on the read port as a field that differs from the model. For this reason the bench reads back every entry after every cycle, not only the entry just written. A wrong base, selector or type shows on the read port from the edge right after the write. A flush request that is missing, late or stretched shows on `flush_req` one cycle after the write edge. Random loads that mix both modes, all eight index codes and idle cycles are compared against a bench model. Directed cases cover the mode switch that keeps privilege 3 through a real-mode load, the two unused indices, and back-to-back code segment loads.

// File: rtl/rv86_seg_pkg.sv
// Package: shared cache entry type and the load rules for real and
// virtual-8086 segment register writes. Assumes 16-bit segment values
// and a 32-bit linear base.
package rv86_seg_pkg;

    localparam int SEL_W     = 16;
    localparam int BASE_W    = 32;
    localparam int LIMRAW_W  = 20;
    localparam int LIMSCL_W  = 32;
    localparam int SHIFT     = 4;
    localparam logic [3:0] TYPE_RW_ACC = 4'b0011;
    localparam logic [1:0] V86_PRIV    = 2'd3;
    localparam logic [15:0] SMALL_LIM  = 16'hFFFF;

    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic [1:0]          rpl;
        logic                valid;
        logic                present;
        logic                nonsys;
        logic [3:0]          kind;
        logic [1:0]          dpl;
        logic [BASE_W-1:0]   base;
        logic [LIMRAW_W-1:0] lim_raw;
        logic [LIMSCL_W-1:0] lim_scaled;
        logic                gran;
        logic                dsize;
        logic                lmode;
        logic                avail;
    } seg_cache_t;

    // Entry contents after reset: valid real-mode data segment at base 0.
    function automatic seg_cache_t cache_reset();
        seg_cache_t c;
        c            = '0;
        c.valid      = 1'b1;
        c.present    = 1'b1;
        c.nonsys     = 1'b1;
        c.kind       = TYPE_RW_ACC;
        c.lim_raw    = LIMRAW_W'(SMALL_LIM);
        c.lim_scaled = LIMSCL_W'(SMALL_LIM);
        return c;
    endfunction

    // New entry contents for a load of 'value' in the given mode.
    function automatic seg_cache_t cache_load(seg_cache_t cur,
                                              logic [SEL_W-1:0] value,
                                              logic v86);
        seg_cache_t c;
        c         = cur;
        c.sel     = value;
        c.rpl     = v86 ? V86_PRIV : 2'd0;
        c.base    = BASE_W'({value, {SHIFT{1'b0}}});
        c.valid   = 1'b1;
        c.present = 1'b1;
        c.nonsys  = 1'b1;
        c.kind    = TYPE_RW_ACC;
        if (v86) begin
            c.dpl        = V86_PRIV;
            c.lim_raw    = LIMRAW_W'(SMALL_LIM);
            c.lim_scaled = LIMSCL_W'(SMALL_LIM);
            c.gran       = 1'b0;
            c.dsize      = 1'b0;
            c.lmode      = 1'b0;
            c.avail      = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/rv86_seg_entry.sv
// Module: one segment cache register. It loads on 'wen' following the
// real / virtual-8086 rules and otherwise holds. Assumes the caller
// decodes the index and gates 'wen'.
module rv86_seg_entry
    import rv86_seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [SEL_W-1:0]  value,
    input  logic              v86,
    output seg_cache_t        q
);

    // Storage: reset to the real-mode default, load on a write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= cache_reset();
        end else if (wen) begin
            q <= cache_load(q, value, v86);
        end
    end

    // R2: selector and base follow the written value.
    assert_load_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wen && rst_n) |-> (q.sel == $past(value)) &&
                                (q.base == {12'h000, $past(value), 4'h0}));

    // R3 / R4: privilege of the selector and the fixed flags after a load.
    assert_load_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wen && rst_n) |-> q.valid && q.present && q.nonsys &&
                                (q.kind == 4'b0011) &&
                                (q.rpl == ($past(v86) ? 2'd3 : 2'd0)));

    // R5: a real-mode load keeps privilege, limits and attribute bits.
    assert_real_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wen && rst_n && !v86) |->
            (q.dpl == $past(q.dpl)) && (q.lim_raw == $past(q.lim_raw)) &&
            (q.lim_scaled == $past(q.lim_scaled)) &&
            ({q.gran, q.dsize, q.lmode, q.avail} ==
             $past({q.gran, q.dsize, q.lmode, q.avail})));

    // R6: a virtual-8086 load forces the fixed 64 KiB 16-bit segment.
    assert_v86_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wen && rst_n && v86) |->
            (q.dpl == 2'd3) && (q.lim_raw == 20'hFFFF) &&
            (q.lim_scaled == 32'hFFFF) &&
            ({q.gran, q.dsize, q.lmode, q.avail} == 4'b0000));

    // R8: no write means the entry holds.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wen && rst_n) |-> (q == $past(q)));

endmodule

// File: rtl/rv86_seg_rdmux.sv
// Module: read-out selector over the packed array of cache entries.
// Assumes indices at or above NUM_SEGS are unused and return zero.
module rv86_seg_rdmux
    import rv86_seg_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    localparam int IDX_W   = $clog2(NUM_SEGS)
)(
    input  seg_cache_t [NUM_SEGS-1:0] caches,
    input  logic [IDX_W-1:0]          sel,
    output seg_cache_t                out
);

    // Pick the addressed entry, or zero for an unused index.
    always_comb begin
        out = '0;
        for (int i = 0; i < NUM_SEGS; i++) begin
            if (int'(sel) == i) out = caches[i];
        end
    end

endmodule

// File: rtl/rv86_seg_loader.sv
// Module: top of the real / virtual-8086 segment loader. It holds
// NUM_SEGS cache entries with one write port and one read port, and
// raises a one-cycle flush request after every code segment load.
// Assumes the core only uses this path when protection is off or in
// virtual-8086 mode.
module rv86_seg_loader
    import rv86_seg_pkg::*;
#(
    parameter int NUM_SEGS = 6,
    parameter int CODE_IDX = 1,
    localparam int IDX_W   = $clog2(NUM_SEGS)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_sel,
    input  logic [SEL_W-1:0]     wr_value,
    input  logic                 v86_mode,
    input  logic [IDX_W-1:0]     rd_sel,
    output logic [SEL_W-1:0]     rd_selector,
    output logic [1:0]           rd_rpl,
    output logic                 rd_valid,
    output logic                 rd_present,
    output logic                 rd_nonsys,
    output logic [3:0]           rd_type,
    output logic [1:0]           rd_dpl,
    output logic [BASE_W-1:0]    rd_base,
    output logic [LIMRAW_W-1:0]  rd_limit_raw,
    output logic [LIMSCL_W-1:0]  rd_limit_scaled,
    output logic                 rd_gran,
    output logic                 rd_dsize,
    output logic                 rd_long,
    output logic                 rd_avail,
    output logic                 flush_req
);

    seg_cache_t [NUM_SEGS-1:0] caches;
    seg_cache_t                rd_entry;
    logic                      code_wr;

    // One cache register per segment, each enabled by its own index match.
    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (int'(wr_sel) == g);
        rv86_seg_entry u_entry (
            .clk   (clk),
            .rst_n (rst_n),
            .wen   (hit),
            .value (wr_value),
            .v86   (v86_mode),
            .q     (caches[g])
        );
    end

    rv86_seg_rdmux #(.NUM_SEGS(NUM_SEGS)) u_rdmux (
        .caches (caches),
        .sel    (rd_sel),
        .out    (rd_entry)
    );

    // Spread the selected entry onto the read ports.
    always_comb begin
        rd_selector     = rd_entry.sel;
        rd_rpl          = rd_entry.rpl;
        rd_valid        = rd_entry.valid;
        rd_present      = rd_entry.present;
        rd_nonsys       = rd_entry.nonsys;
        rd_type         = rd_entry.kind;
        rd_dpl          = rd_entry.dpl;
        rd_base         = rd_entry.base;
        rd_limit_raw    = rd_entry.lim_raw;
        rd_limit_scaled = rd_entry.lim_scaled;
        rd_gran         = rd_entry.gran;
        rd_dsize        = rd_entry.dsize;
        rd_long         = rd_entry.lmode;
        rd_avail        = rd_entry.avail;
    end

    assign code_wr = wr_en && (int'(wr_sel) == CODE_IDX);

    // Flush request: registered so it appears in the cycle after the load.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_req <= 1'b0;
        else        flush_req <= code_wr;
    end

    // R7: a flush only follows a code segment write.
    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> $past(rst_n && wr_en && (int'(wr_sel) == CODE_IDX)));

    // R7: every code segment write produces the flush.
    assert_flush_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_sel) == CODE_IDX)) |=> flush_req);

    // R1: the flush output is low on the first cycle out of reset.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !flush_req);

endmodule

// File: tb/rv86_seg_loader_bench.sv
`timescale 1ns/1ps
module rv86_seg_loader_bench;

    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_value;
    logic        v86_mode;
    logic [2:0]  rd_sel;
    logic [15:0] rd_selector;
    logic [1:0]  rd_rpl;
    logic        rd_valid, rd_present, rd_nonsys;
    logic [3:0]  rd_type;
    logic [1:0]  rd_dpl;
    logic [31:0] rd_base;
    logic [19:0] rd_limit_raw;
    logic [31:0] rd_limit_scaled;
    logic        rd_gran, rd_dsize, rd_long, rd_avail;
    logic        flush_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of each entry.
    logic [15:0] m_sel [N];
    logic [1:0]  m_rpl [N];
    logic [1:0]  m_dpl [N];
    logic [31:0] m_base [N];
    logic [19:0] m_limr [N];
    logic [31:0] m_lims [N];
    logic [3:0]  m_attr [N];
    logic        m_flush;

    always #2.5 clk = ~clk;

    rv86_seg_loader u_rv86_seg_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_value(wr_value), .v86_mode(v86_mode), .rd_sel(rd_sel),
        .rd_selector(rd_selector), .rd_rpl(rd_rpl), .rd_valid(rd_valid),
        .rd_present(rd_present), .rd_nonsys(rd_nonsys), .rd_type(rd_type),
        .rd_dpl(rd_dpl), .rd_base(rd_base), .rd_limit_raw(rd_limit_raw),
        .rd_limit_scaled(rd_limit_scaled), .rd_gran(rd_gran),
        .rd_dsize(rd_dsize), .rd_long(rd_long), .rd_avail(rd_avail),
        .flush_req(flush_req)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_sel[i] = 16'h0; m_rpl[i] = 2'd0; m_dpl[i] = 2'd0;
            m_base[i] = 32'h0; m_limr[i] = 20'hFFFF; m_lims[i] = 32'hFFFF;
            m_attr[i] = 4'h0;
        end
        m_flush = 1'b0;
    endtask

    // Expected effect of one input cycle, from the requirements.
    task automatic model_step(logic en, logic [2:0] s, logic [15:0] v, logic v86);
        m_flush = en && (s == 3'd1);
        if (en && s < 3'(N)) begin
            m_sel[s]  = v;
            m_base[s] = {12'h000, v, 4'h0};
            m_rpl[s]  = v86 ? 2'd3 : 2'd0;
            if (v86) begin
                m_dpl[s] = 2'd3; m_limr[s] = 20'hFFFF;
                m_lims[s] = 32'hFFFF; m_attr[s] = 4'h0;
            end
        end
    endtask

    task automatic check_entry(int k, string tag);
        rd_sel = 3'(k);
        #0.2;
        check(tag, $sformatf("sel[%0d]", k), 64'(rd_selector), 64'(m_sel[k]));
        check(tag, $sformatf("base[%0d]", k), 64'(rd_base), 64'(m_base[k]));
        check(tag, $sformatf("rpl[%0d]", k), 64'(rd_rpl), 64'(m_rpl[k]));
        check(tag, $sformatf("flags[%0d]", k),
              64'({rd_valid, rd_present, rd_nonsys, rd_type}), 64'(7'b1110011));
        check(tag, $sformatf("dpl[%0d]", k), 64'(rd_dpl), 64'(m_dpl[k]));
        check(tag, $sformatf("limits[%0d]", k),
              64'({rd_limit_raw, rd_limit_scaled}), 64'({m_limr[k], m_lims[k]}));
        check(tag, $sformatf("attrs[%0d]", k),
              64'({rd_gran, rd_dsize, rd_long, rd_avail}), 64'(m_attr[k]));
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < N; k++) check_entry(k, tag);
    endtask

    // Drive one cycle at the falling edge, then check after the rising edge.
    task automatic cycle(logic en, logic [2:0] s, logic [15:0] v, logic v86, string tag);
        wr_en = en; wr_sel = s; wr_value = v; v86_mode = v86;
        @(negedge clk);
        wr_en = 1'b0;
        model_step(en, s, v, v86);
        check("R7", $sformatf("flush %s", tag), 64'(flush_req), 64'(m_flush));
        check_all(tag);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_0B1E));
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 3'd0; wr_value = 16'h0;
        v86_mode = 1'b0; rd_sel = 3'd0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset contents and quiet flush.
        check("R1", "flush after reset", 64'(flush_req), 64'd0);
        check_all("R1");

        // R2 R3 R4 R7: real-mode code segment load.
        cycle(1'b1, 3'd1, 16'h1234, 1'b0, "R2");
        // R6 R3: virtual-8086 load of index 3.
        cycle(1'b1, 3'd3, 16'hFFFF, 1'b1, "R6");
        // R5: real-mode load after the v86 load keeps privilege 3.
        cycle(1'b1, 3'd3, 16'h0800, 1'b0, "R5");
        rd_sel = 3'd3; #0.2;
        check("R5", "dpl kept through real load", 64'(rd_dpl), 64'd3);
        check("R3", "rpl back to 0", 64'(rd_rpl), 64'd0);
        // R8: unused indices and a disabled strobe change nothing.
        cycle(1'b1, 3'd6, 16'hAAAA, 1'b1, "R8");
        cycle(1'b1, 3'd7, 16'h5555, 1'b0, "R8");
        cycle(1'b0, 3'd1, 16'h7777, 1'b1, "R8");
        // R9: unused read index returns zero.
        rd_sel = 3'd7; #0.2;
        check("R9", "read idx 7", 64'({rd_selector, rd_base, rd_valid, rd_type, rd_limit_raw}), 64'd0);
        rd_sel = 3'd6; #0.2;
        check("R9", "read idx 6", 64'({rd_selector, rd_base, rd_present, rd_dpl, rd_limit_scaled}), 64'd0);
        // R7: back-to-back code loads, then a non-code load.
        cycle(1'b1, 3'd1, 16'h0001, 1'b1, "R7");
        cycle(1'b1, 3'd1, 16'hF000, 1'b0, "R7");
        cycle(1'b1, 3'd2, 16'h0042, 1'b0, "R7");
        check("R7", "flush dropped", 64'(flush_req), 64'd0);

        // Mixed random loads over all index codes and both modes.
        for (int i = 0; i < 400; i++) begin
            logic en;
            logic [2:0] s;
            logic [15:0] v;
            logic md;
            en = ($urandom % 4) != 0;
            s  = 3'($urandom % 8);
            v  = 16'($urandom);
            md = 1'($urandom % 2);
            cycle(en, s, v, md, "R8");
        end

        // R1: a second reset restores the defaults.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule